// File: doc/BRIEF.md
# Coprocessor-to-FIFO-stream instruction bridge

This block sits between a processor's coprocessor instruction port and a bank of FIFO-style stream channels. The number of channel pairs is set by a parameter. Each pair has an outbound channel that the bridge writes and an inbound channel that the bridge reads. Every stream word is a data field plus one control bit. The processor hands over an instruction that is already decoded into three parts: an opcode, a channel index and write data. The bridge then pops one word from the selected inbound channel or pushes one word to the selected outbound channel.

The opcode gives three choices: read or write, blocking or non-blocking, and data or control. A blocking access waits until its channel can take part. A non-blocking access gives up at once and reports failure. On a read, a mismatch between the control bit of the word and the type the instruction expects raises an error flag. The processor side uses a valid/ready handshake. Only one instruction is in flight at a time. The bridge ends each instruction with a one-cycle done pulse that carries the read data and both flags.

Top module: `cop_stream_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `ins_ready` is 1, and `done`, `rdata`, `ctl_err`, `nb_fail`, every `s_rd` bit and every `m_wr` bit are 0.
- R2: `ins_ready` is 1 only when no instruction is in flight. An instruction accepted on a clock edge drops `ins_ready` in the next cycle. That instruction produces exactly one single-cycle `done` pulse, and `ins_ready` returns to 1 in the same cycle as that pulse.
- R3: A blocking read to a valid channel waits while that channel's `s_valid` is 0, with `done` held low. In the cycle that `s_valid` is seen, the bridge raises `s_rd` of that channel alone for exactly one cycle. In the next cycle `done` is 1 and `rdata` equals the popped word.
- R4: A blocking write to a valid channel waits while that channel's `m_full` is 1. In the first cycle it sees `m_full` at 0, the bridge raises `m_wr` of that channel alone for exactly one cycle, with that lane's `m_data` equal to the write data. In the next cycle `done` is 1 and `rdata` is 0.
- R5: When a read pops a word, `ctl_err` comes with `done` and is 1 exactly when the word's control bit differs from opcode bit 0. `ctl_err` is always 0 for writes and for failed accesses.
- R6: A non-blocking read whose channel has `s_valid` at 0 completes one cycle after the bridge evaluates it. It then gives `nb_fail`=1 and `rdata`=0, and pulses no `s_rd` bit.
- R7: A non-blocking write whose channel has `m_full` at 1 completes one cycle after the bridge evaluates it. It then gives `nb_fail`=1 and pulses no `m_wr` bit. A non-blocking access that succeeds gives `nb_fail`=0.
- R8: An index at or above `NPAIRS` completes one cycle after evaluation for every opcode, blocking ones included. It gives `nb_fail`=1, `ctl_err`=0 and `rdata`=0, and pulses no strobe.
- R9: Opcode encoding: bit 2 is 1 for a write and 0 for a read, bit 1 is 1 for non-blocking, and bit 0 is 1 for a control-type access. A write drives the outbound control bit `m_ctrl` to opcode bit 0, so a control write gives 1 and a data write gives 0.
- R10: While `done` is 0, `rdata`, `ctl_err` and `nb_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Bridge idle, instruction accepted when valid |
| ins_op | input | 3 | Opcode {write, non-blocking, control} |
| ins_chan | input | 5 | Channel pair index |
| ins_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read result, valid with done |
| ctl_err | output | 1 | Control-bit mismatch flag, valid with done |
| nb_fail | output | 1 | Failed access flag, valid with done |
| m_data | output | NPAIRS*DW | Outbound data, lane i at bits [i*DW +: DW] |
| m_ctrl | output | NPAIRS | Outbound control bit per lane |
| m_wr | output | NPAIRS | Outbound write strobe per lane |
| m_full | input | NPAIRS | Outbound channel full per lane |
| s_data | input | NPAIRS*DW | Inbound head word data per lane |
| s_ctrl | input | NPAIRS | Inbound head word control bit per lane |
| s_valid | input | NPAIRS | Inbound word available per lane |
| s_rd | output | NPAIRS | Inbound pop strobe per lane |

## Verification
An instruction accepted on edge k is evaluated in the cycle after edge k. The strobe for a channel that is ready falls in that same cycle, and `done` with its data and flags follows one edge later. A stalled blocking access finishes one edge after the cycle in which the bench makes its channel ready. The bench drives its inputs on the falling edge and checks the registered outputs on the next falling edge, because completion is due there. It counts strobes a quarter period after each falling edge, so every pulse is seen once in the cycle it belongs to. The sweep covers all eight opcodes, indices both inside and outside the pair count, channels ready or not, and both inbound control values. For each case the bench also checks that `done` and the flags have dropped one cycle later.

// File: rtl/csb_pkg.sv
// Package: shared types for the coprocessor stream bridge.
// Assumes: channel index is at most 5 bits (up to 32 pairs).
package csb_pkg;
    localparam int IDXW = 5;

    // Decoded opcode: bit 2 write, bit 1 non-blocking, bit 0 control type
    typedef struct packed {
        logic is_wr;
        logic nonblk;
        logic ctl;
    } op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } st_t;
endpackage

// File: rtl/csb_chan_mux.sv
// Module: csb_chan_mux
// Selects the inbound word, valid, control bit and outbound full flag of
// the latched channel, and flags an index outside the configured pairs.
// Assumes: NPAIRS in 1..32; index is held stable by the sequencer.
module csb_chan_mux
    import csb_pkg::*;
#(
    parameter int NPAIRS = 4,
    parameter int DW     = 32
) (
    input  logic [IDXW-1:0]      chan,
    input  logic [NPAIRS*DW-1:0] s_data,
    input  logic [NPAIRS-1:0]    s_ctrl,
    input  logic [NPAIRS-1:0]    s_valid,
    input  logic [NPAIRS-1:0]    m_full,
    output logic [DW-1:0]        sel_data,
    output logic                 sel_ctrl,
    output logic                 sel_valid,
    output logic                 sel_full,
    output logic                 chan_bad
);
    // Range check: an index at or above NPAIRS selects nothing
    always_comb begin
        chan_bad = ({1'b0, chan} >= (IDXW + 1)'(NPAIRS));
    end

    // One-hot style selection across the configured lanes
    always_comb begin
        sel_data  = '0;
        sel_ctrl  = 1'b0;
        sel_valid = 1'b0;
        sel_full  = 1'b0;
        for (int i = 0; i < NPAIRS; i++) begin
            if (chan == IDXW'(i)) begin
                sel_data  = s_data[i*DW +: DW];
                sel_ctrl  = s_ctrl[i];
                sel_valid = s_valid[i];
                sel_full  = m_full[i];
            end
        end
    end
endmodule

// File: rtl/csb_seq.sv
// Module: csb_seq
// Two-state sequencer: accepts one instruction, evaluates it each cycle
// against the selected channel, issues pop or push enables and registers
// the completion pulse with read data and flags.
// Assumes: inbound channels present their head word while valid
// (fall-through), so a pop strobe and data capture share one cycle.
module csb_seq
    import csb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [2:0]      ins_op,
    input  logic [IDXW-1:0] ins_chan,
    input  logic [DW-1:0]   ins_wdata,
    input  logic [DW-1:0]   sel_data,
    input  logic            sel_ctrl,
    input  logic            sel_valid,
    input  logic            sel_full,
    input  logic            chan_bad,
    output logic            ins_ready,
    output logic            rd_go,
    output logic            wr_go,
    output logic [IDXW-1:0] cur_chan,
    output logic [DW-1:0]   cur_wdata,
    output logic            cur_ctl,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic            ctl_err,
    output logic            nb_fail
);
    st_t st;
    op_t cur_op;
    logic finish;
    logic res_ok;

    // Idle state is the only state that takes an instruction
    always_comb begin
        ins_ready = (st == ST_IDLE);
        cur_ctl   = cur_op.ctl;
    end

    // Evaluate the in-flight instruction against the selected channel
    always_comb begin
        res_ok = cur_op.is_wr ? !sel_full : sel_valid;
        rd_go  = (st == ST_EXEC) && !chan_bad && res_ok && !cur_op.is_wr;
        wr_go  = (st == ST_EXEC) && !chan_bad && res_ok && cur_op.is_wr;
        finish = (st == ST_EXEC) && (chan_bad || res_ok || cur_op.nonblk);
    end

    // State, latched instruction and registered completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_op    <= '0;
            cur_chan  <= '0;
            cur_wdata <= '0;
            done      <= 1'b0;
            rdata     <= '0;
            ctl_err   <= 1'b0;
            nb_fail   <= 1'b0;
        end else begin
            done    <= 1'b0;
            rdata   <= '0;
            ctl_err <= 1'b0;
            nb_fail <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (ins_valid) begin
                        cur_op    <= op_t'(ins_op);
                        cur_chan  <= ins_chan;
                        cur_wdata <= ins_wdata;
                        st        <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (finish) begin
                        st      <= ST_IDLE;
                        done    <= 1'b1;
                        nb_fail <= !(rd_go || wr_go);
                        if (rd_go) begin
                            rdata   <= sel_data;
                            ctl_err <= sel_ctrl ^ cur_op.ctl;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/csb_strobe_dec.sv
// Module: csb_strobe_dec
// Expands pop and push enables into per-lane strobes and drives every
// outbound lane with the latched write word and control bit.
// Assumes: at most one of rd_go / wr_go is high; out-of-range index
// never comes with an enable.
module csb_strobe_dec
    import csb_pkg::*;
#(
    parameter int NPAIRS = 4,
    parameter int DW     = 32
) (
    input  logic [IDXW-1:0]      chan,
    input  logic                 rd_go,
    input  logic                 wr_go,
    input  logic [DW-1:0]        wdata,
    input  logic                 ctl,
    output logic [NPAIRS-1:0]    s_rd,
    output logic [NPAIRS-1:0]    m_wr,
    output logic [NPAIRS*DW-1:0] m_data,
    output logic [NPAIRS-1:0]    m_ctrl
);
    for (genvar i = 0; i < NPAIRS; i++) begin : g_lane
        // Per-lane strobe decode and outbound word broadcast
        always_comb begin
            s_rd[i]              = rd_go && (chan == IDXW'(i));
            m_wr[i]              = wr_go && (chan == IDXW'(i));
            m_data[i*DW +: DW]   = wdata;
            m_ctrl[i]            = ctl;
        end
    end
endmodule

// File: rtl/cop_stream_bridge.sv
// Module: cop_stream_bridge (top)
// Bridges decoded coprocessor instructions to NPAIRS pairs of FIFO-style
// stream channels: blocking / non-blocking, data / control reads and
// writes, with control-mismatch and failed-access flags.
// Assumes: NPAIRS in 1..32; one instruction in flight at a time.
module cop_stream_bridge
    import csb_pkg::*;
#(
    parameter int NPAIRS = 4,
    parameter int DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_valid,
    output logic                 ins_ready,
    input  logic [2:0]           ins_op,
    input  logic [4:0]           ins_chan,
    input  logic [DW-1:0]        ins_wdata,
    output logic                 done,
    output logic [DW-1:0]        rdata,
    output logic                 ctl_err,
    output logic                 nb_fail,
    output logic [NPAIRS*DW-1:0] m_data,
    output logic [NPAIRS-1:0]    m_ctrl,
    output logic [NPAIRS-1:0]    m_wr,
    input  logic [NPAIRS-1:0]    m_full,
    input  logic [NPAIRS*DW-1:0] s_data,
    input  logic [NPAIRS-1:0]    s_ctrl,
    input  logic [NPAIRS-1:0]    s_valid,
    output logic [NPAIRS-1:0]    s_rd
);
    logic [IDXW-1:0] cur_chan;
    logic [DW-1:0]   cur_wdata;
    logic            cur_ctl;
    logic [DW-1:0]   sel_data;
    logic            sel_ctrl, sel_valid, sel_full, chan_bad;
    logic            rd_go, wr_go;

    csb_chan_mux #(.NPAIRS(NPAIRS), .DW(DW)) u_mux (
        .chan      (cur_chan),
        .s_data    (s_data),
        .s_ctrl    (s_ctrl),
        .s_valid   (s_valid),
        .m_full    (m_full),
        .sel_data  (sel_data),
        .sel_ctrl  (sel_ctrl),
        .sel_valid (sel_valid),
        .sel_full  (sel_full),
        .chan_bad  (chan_bad)
    );

    csb_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_op    (ins_op),
        .ins_chan  (ins_chan),
        .ins_wdata (ins_wdata),
        .sel_data  (sel_data),
        .sel_ctrl  (sel_ctrl),
        .sel_valid (sel_valid),
        .sel_full  (sel_full),
        .chan_bad  (chan_bad),
        .ins_ready (ins_ready),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .cur_chan  (cur_chan),
        .cur_wdata (cur_wdata),
        .cur_ctl   (cur_ctl),
        .done      (done),
        .rdata     (rdata),
        .ctl_err   (ctl_err),
        .nb_fail   (nb_fail)
    );

    csb_strobe_dec #(.NPAIRS(NPAIRS), .DW(DW)) u_dec (
        .chan   (cur_chan),
        .rd_go  (rd_go),
        .wr_go  (wr_go),
        .wdata  (cur_wdata),
        .ctl    (cur_ctl),
        .s_rd   (s_rd),
        .m_wr   (m_wr),
        .m_data (m_data),
        .m_ctrl (m_ctrl)
    );
endmodule

// File: rtl/csb_checker.sv
// Module: csb_checker
// Protocol assertions for cop_stream_bridge, attached by bind.
// Assumes: same parameters as the bridge instance it watches.
module csb_checker #(
    parameter int NPAIRS = 4,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic              done,
    input logic [DW-1:0]     rdata,
    input logic              ctl_err,
    input logic              nb_fail,
    input logic [NPAIRS-1:0] s_valid,
    input logic [NPAIRS-1:0] s_rd,
    input logic [NPAIRS-1:0] m_full,
    input logic [NPAIRS-1:0] m_wr
);
    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |=> !ins_ready);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ins_ready);
    // R3
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rd));
    // R4
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_wr));
    // R3
    rd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_rd) |=> (done && !(|s_rd)));
    // R4
    wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_wr) |=> (done && !(|m_wr)));
    // R9
    no_rd_wr_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|s_rd) && (|m_wr)));
    // R10
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rdata == '0 && !ctl_err && !nb_fail));

    for (genvar i = 0; i < NPAIRS; i++) begin : g_lane_chk
        // R3
        rd_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_rd[i] |-> s_valid[i]);
        // R4
        wr_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_wr[i] |-> !m_full[i]);
    end
endmodule

bind cop_stream_bridge csb_checker #(.NPAIRS(NPAIRS), .DW(DW)) u_chk (.*);

// File: tb/tb_cop_stream_bridge.sv
// Bench: sweeps every opcode, indices in and out of range, channel
// readiness and inbound control bit on a 3-pair, 8-bit configuration.
module tb_cop_stream_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0;
    logic ins_ready;
    logic [2:0] ins_op = '0;
    logic [4:0] ins_chan = '0;
    logic [DW-1:0] ins_wdata = '0;
    logic done;
    logic [DW-1:0] rdata;
    logic ctl_err, nb_fail;
    logic [NP*DW-1:0] m_data;
    logic [NP-1:0] m_ctrl, m_wr;
    logic [NP-1:0] m_full = '0;
    logic [NP*DW-1:0] s_data = '0;
    logic [NP-1:0] s_ctrl = '0;
    logic [NP-1:0] s_valid = '0;
    logic [NP-1:0] s_rd;

    int checks = 0;
    int errors = 0;
    int rd_cnt [NP];
    int wr_cnt [NP];
    logic [DW-1:0] last_md = '0;
    logic last_mc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_stream_bridge #(.NPAIRS(NP), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_op(ins_op), .ins_chan(ins_chan), .ins_wdata(ins_wdata),
        .done(done), .rdata(rdata), .ctl_err(ctl_err), .nb_fail(nb_fail),
        .m_data(m_data), .m_ctrl(m_ctrl), .m_wr(m_wr), .m_full(m_full),
        .s_data(s_data), .s_ctrl(s_ctrl), .s_valid(s_valid), .s_rd(s_rd)
    );

    // Strobe monitor: a quarter period after the falling edge
    initial begin
        for (int i = 0; i < NP; i++) begin rd_cnt[i] = 0; wr_cnt[i] = 0; end
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            for (int i = 0; i < NP; i++) begin
                if (s_rd[i]) rd_cnt[i]++;
                if (m_wr[i]) begin
                    wr_cnt[i]++;
                    last_md = m_data[i*DW +: DW];
                    last_mc = m_ctrl[i];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int op, input int ch, input int avail, input int wctrl);
        bit wr = op[2];
        bit nb = op[1];
        bit c  = op[0];
        bit bad = (ch >= NP);
        bit success = !bad && (avail != 0 || !nb);
        int base = (op*37 + ch*11 + avail*5 + wctrl*3) & 8'hFF;
        int wd = base ^ 8'h5A;
        int rd0 [NP];
        int wr0 [NP];
        int exp_rd, exp_err, exp_fail;
        string rq = wr ? "R4" : "R3";
        string fq = bad ? "R8" : (wr ? "R7" : "R6");

        for (int i = 0; i < NP; i++) begin
            s_data[i*DW +: DW] = 8'(base + i*16);
            s_ctrl[i]  = (i == ch) ? wctrl[0] : ~wctrl[0];
            s_valid[i] = (i == ch) ? avail[0] : 1'b1;
            m_full[i]  = (i == ch) ? ~avail[0] : 1'b0;
            rd0[i] = rd_cnt[i];
            wr0[i] = wr_cnt[i];
        end
        ins_valid = 1'b1;
        ins_op    = 3'(op);
        ins_chan  = 5'(ch);
        ins_wdata = 8'(wd);
        chk(ins_ready == 1'b1, "R2", "ready before accept", ins_ready, 1);
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(ins_ready == 1'b0, "R2", "ready while in flight", ins_ready, 0);
        chk(done == 1'b0, rq, "done in evaluate cycle", done, 0);
        if (!bad && !nb && avail == 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(done == 1'b0, rq, "done while stalled", done, 0);
            end
            for (int i = 0; i < NP; i++)
                chk(rd_cnt[i] == rd0[i] && wr_cnt[i] == wr0[i], rq,
                    "strobe while stalled", rd_cnt[i] + wr_cnt[i], rd0[i] + wr0[i]);
            s_valid[ch] = 1'b1;
            m_full[ch]  = 1'b0;
        end
        @(negedge clk);
        chk(done == 1'b1, wr ? "R4" : "R3", "done pulse", done, 1);
        exp_rd   = (!wr && success) ? ((base + ch*16) & 8'hFF) : 0;
        exp_err  = (!wr && success) ? int'(wctrl[0] != c) : 0;
        exp_fail = success ? 0 : 1;
        chk(rdata == 8'(exp_rd), bad ? "R8" : rq, "rdata", rdata, exp_rd);
        chk(ctl_err == exp_err[0], "R5", "ctl_err", ctl_err, exp_err);
        chk(nb_fail == exp_fail[0], fq, "nb_fail", nb_fail, exp_fail);
        for (int i = 0; i < NP; i++) begin
            int er = (!wr && success && i == ch) ? 1 : 0;
            int ew = (wr && success && i == ch) ? 1 : 0;
            chk(rd_cnt[i] - rd0[i] == er, bad ? "R8" : "R3", "pop count",
                rd_cnt[i] - rd0[i], er);
            chk(wr_cnt[i] - wr0[i] == ew, bad ? "R8" : "R4", "push count",
                wr_cnt[i] - wr0[i], ew);
        end
        if (wr && success) begin
            chk(last_md == 8'(wd), "R4", "pushed data", last_md, wd);
            chk(last_mc == c, "R9", "pushed control bit", last_mc, c);
        end
        @(negedge clk);
        chk(done == 1'b0, "R2", "done drops", done, 0);
        chk(ins_ready == 1'b1, "R2", "ready after done", ins_ready, 1);
        chk(rdata == '0 && !ctl_err && !nb_fail, "R10", "outputs idle",
            {rdata, ctl_err, nb_fail}, 0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ins_ready == 1'b1 && done == 1'b0, "R1", "ready/done in reset",
            {ins_ready, done}, 2);
        chk(s_rd == '0 && m_wr == '0, "R1", "strobes in reset", {s_rd, m_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == '0 && !ctl_err && !nb_fail, "R1", "outputs after reset",
            {rdata, ctl_err, nb_fail}, 0);
        chk(ins_ready == 1'b1, "R1", "ready after reset", ins_ready, 1);
        for (int op = 0; op < 8; op++)
            for (int ch = 0; ch < 5; ch++)
                for (int av = 0; av < 2; av++)
                    for (int wc = 0; wc < 2; wc++)
                        run_case(op, ch, av, wc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule